// File: doc/BRIEF.md
# Length Encoder and Block-Pad Framer

This block builds the framing byte streams that customizable Keccak functions and keyed Keccak MACs need around their inputs. A command carries an operation code and a length value of up to 64 bits. The block turns the value into a self-delimiting byte string. Leading zero bytes are dropped, so the string holds only the bytes that matter, and a single count byte saying how many value bytes follow is placed either before or after them. Value bytes always leave most-significant byte first.

Two operations wrap a second byte stream that arrives on a pass-through input. The string-header operation sends the length of a string, given in bytes and encoded in bits, with the count byte first. It then forwards the string bytes. The block-pad operation first sends the encoded block width. It then forwards the wrapped bytes and appends zero bytes until the total byte count of the operation is a whole multiple of the block width. The block width is 168 or 136. The output is a valid/ready byte stream. It holds its byte while the sink stalls, and a last flag marks the final byte of each operation.

Top module: `sp_len_framer`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an operation, out_valid is 0, in_ready is 0 and cmd_ready is 1.
- R2: Operation code 0 (count-first) emits the count byte n, then the n value bytes most-significant first, with out_last on the final value byte.
- R3: Operation code 1 (count-last) emits the n value bytes most-significant first, then the count byte n, with out_last on the count byte.
- R4: n is the smallest number of bytes holding the value, with leading zero bytes removed. A value of zero gives n = 1 and one value byte 0x00.
- R5: Operation code 2 (string header) takes cmd_value as a length in bytes and emits the count-first encoding of 8 × cmd_value. It then forwards input bytes unchanged until the one marked in_last, which carries out_last. A length of zero emits only 0x01 0x00.
- R6: Operation code 3 (block pad) starts with the count-first encoding of the block width: 0x01 0xA8 (width 168) when cmd_rate_sel is 0, and 0x01 0x88 (width 136) when it is 1. It then forwards input bytes up to the one marked in_last.
- R7: In block-pad mode, when the bytes emitted so far (header included) are not a multiple of the width, zero bytes follow until they are, with out_last on the final zero byte.
- R8: In block-pad mode, when the total is already a multiple of the width after the last input byte, no zero byte is added and out_last sits on that last forwarded byte.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold, and no byte is lost or repeated.
- R10: cmd_ready is 1 only while no operation is in progress, and it drops in the cycle after a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_op | input | 2 | 0 count-first, 1 count-last, 2 string header, 3 block pad |
| cmd_value | input | VALUE_W (64) | Value to encode (string length in bytes for op 2; unused for op 3) |
| cmd_rate_sel | input | 1 | Block width for op 3: 0 gives 168, 1 gives 136 |
| in_valid | input | 1 | Pass-through byte offered |
| in_ready | output | 1 | Pass-through byte taken |
| in_data | input | 8 | Pass-through byte |
| in_last | input | 1 | Marks the final pass-through byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the operation |

## Verification
Both count-placement orders are tried with values of zero, one byte, two bytes and the full eight bytes, and with a value that has a zero byte in its interior. These cases separate leading-zero stripping from the loss of interior zeros, and they show whether the count byte is off by one. String headers are run with lengths of zero, a one-byte bit length and a two-byte bit length. Block padding is run with both widths at totals one short of a boundary, exactly on it and just past it, which exposes fill counts that are off by one and a last flag on the wrong byte. Several runs hold out_ready low in a repeating pattern to show that bytes are held and none is dropped.

// File: rtl/sp_len_pkg.sv
package sp_len_pkg;

   typedef enum logic [1:0] {
      OP_LEFT    = 2'd0,
      OP_RIGHT   = 2'd1,
      OP_STRING  = 2'd2,
      OP_BYTEPAD = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CNT,
      PH_VAL,
      PH_PASS,
      PH_FILL
   } ph_e;

endpackage

// File: rtl/sp_len_sizer.sv
// Smallest byte count that holds a value; zero counts as one byte.
module sp_len_sizer #(
   parameter int VALUE_W = 64,
   parameter int CNT_W   = 4
) (
   input  logic [VALUE_W-1:0] value,
   output logic [CNT_W-1:0]   nbytes
);
   localparam int NB = VALUE_W / 8;

   logic [NB-1:0] nz;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      assign nz[i] = |value[8*i +: 8];
   end

   always_comb begin
      nbytes = CNT_W'(1);
      for (int i = 0; i < NB; i++) begin
         if (nz[i]) nbytes = CNT_W'(i + 1);
      end
   end
endmodule

// File: rtl/sp_len_modcnt.sv
// Counts emitted bytes modulo the selected block width.
module sp_len_modcnt #(
   parameter int RATE_A = 168,
   parameter int RATE_B = 136
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sel,
   input  logic step,
   output logic at_end
);
   localparam int MAXR = (RATE_A > RATE_B) ? RATE_A : RATE_B;
   localparam int CW   = $clog2(MAXR);

   logic [CW-1:0] cnt_q;
   logic          sel_q;
   logic [CW-1:0] limit;

   assign limit  = sel_q ? CW'(RATE_B - 1) : CW'(RATE_A - 1);
   assign at_end = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= 1'b0;
      end else if (clear) begin
         cnt_q <= '0;
         sel_q <= sel;
      end else if (step) begin
         cnt_q <= at_end ? '0 : cnt_q + CW'(1);
      end
   end
endmodule

// File: rtl/sp_len_framer.sv
module sp_len_framer
   import sp_len_pkg::*;
#(
   parameter int VALUE_W = 64,
   parameter int RATE_A  = 168,
   parameter int RATE_B  = 136
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [1:0]         cmd_op,
   input  logic [VALUE_W-1:0] cmd_value,
   input  logic               cmd_rate_sel,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [7:0]         in_data,
   input  logic               in_last,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [7:0]         out_data,
   output logic               out_last
);
   localparam int NB    = VALUE_W / 8;
   localparam int CNT_W = $clog2(NB + 1);

   if (VALUE_W % 8 != 0 || VALUE_W < 8 || NB > 255) begin : g_bad_width
      $error("VALUE_W must be a whole number of bytes, 1 to 255 of them");
   end
   if (RATE_A < 2 || RATE_A > 255 || RATE_B < 2 || RATE_B > 255) begin : g_bad_rate
      $error("block widths must fit one count byte");
   end

   ph_e                ph_q;
   op_e                op_q;
   logic [VALUE_W-1:0] val_q;
   logic [CNT_W-1:0]   left_q;
   logic [7:0]         n_q;
   logic               pass_q;

   op_e                op_in;
   logic [VALUE_W-1:0] enc_src;
   logic [VALUE_W-1:0] enc_aligned;
   logic [CNT_W-1:0]   enc_n;
   logic               accept;
   logic               fire;
   logic               at_end;

   assign op_in  = op_e'(cmd_op);
   assign accept = cmd_valid && cmd_ready;
   assign fire   = out_valid && out_ready;

   always_comb begin
      unique case (op_in)
         OP_STRING:  enc_src = cmd_value << 3;
         OP_BYTEPAD: enc_src = cmd_rate_sel ? VALUE_W'(RATE_B) : VALUE_W'(RATE_A);
         default:    enc_src = cmd_value;
      endcase
   end

   sp_len_sizer #(.VALUE_W(VALUE_W), .CNT_W(CNT_W)) u_sizer (
      .value  (enc_src),
      .nbytes (enc_n)
   );

   // Move the top significant byte into the top lane.
   assign enc_aligned = enc_src << (8 * (NB - int'(enc_n)));

   sp_len_modcnt #(.RATE_A(RATE_A), .RATE_B(RATE_B)) u_modcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .sel    (cmd_rate_sel),
      .step   (fire),
      .at_end (at_end)
   );

   assign cmd_ready = (ph_q == PH_IDLE);
   assign in_ready  = (ph_q == PH_PASS) && out_ready;

   always_comb begin
      out_valid = 1'b0;
      out_data  = 8'h00;
      out_last  = 1'b0;
      unique case (ph_q)
         PH_CNT: begin
            out_valid = 1'b1;
            out_data  = n_q;
            out_last  = (op_q == OP_RIGHT);
         end
         PH_VAL: begin
            out_valid = 1'b1;
            out_data  = val_q[VALUE_W-1 -: 8];
            out_last  = (left_q == CNT_W'(1)) &&
                        ((op_q == OP_LEFT) || ((op_q == OP_STRING) && !pass_q));
         end
         PH_PASS: begin
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = in_last && ((op_q != OP_BYTEPAD) || at_end);
         end
         PH_FILL: begin
            out_valid = 1'b1;
            out_last  = at_end;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         op_q   <= OP_LEFT;
         val_q  <= '0;
         left_q <= '0;
         n_q    <= '0;
         pass_q <= 1'b0;
      end else if (accept) begin
         op_q   <= op_in;
         val_q  <= enc_aligned;
         left_q <= enc_n;
         n_q    <= 8'(enc_n);
         pass_q <= (op_in == OP_BYTEPAD) ||
                   ((op_in == OP_STRING) && (cmd_value != '0));
         ph_q   <= (op_in == OP_RIGHT) ? PH_VAL : PH_CNT;
      end else if (fire) begin
         if (out_last) begin
            ph_q <= PH_IDLE;
         end else begin
            unique case (ph_q)
               PH_CNT:  ph_q <= PH_VAL;
               PH_VAL: begin
                  val_q  <= val_q << 8;
                  left_q <= left_q - CNT_W'(1);
                  if (left_q == CNT_W'(1)) begin
                     ph_q <= (op_q == OP_RIGHT) ? PH_CNT : PH_PASS;
                  end
               end
               PH_PASS: if (in_last) ph_q <= PH_FILL;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sp_len_framer_chk.sv
module sp_len_framer_chk #(
   parameter int VALUE_W = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [1:0] cmd_op,
   input logic       in_valid,
   input logic       in_ready,
   input logic [7:0] in_data,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_last
);
   localparam int NB = VALUE_W / 8;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !out_valid && !in_ready);                              // R1

   AST_LAST_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> cmd_ready);                   // R2

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_op == 2'd0 |=>
         out_valid && out_data != 8'd0 && out_data <= 8'(NB));            // R4

   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> out_valid && out_ready && out_data == in_data); // R5

   AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=>
         out_valid && $stable(out_data) && $stable(out_last));             // R9

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> !cmd_ready);                              // R10
endmodule

bind sp_len_framer sp_len_framer_chk #(.VALUE_W(VALUE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last)
);

// File: tb/tb_sp_len_framer.sv
module tb_sp_len_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic [63:0] cmd_value = '0;
   logic        cmd_rate_sel = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_last;

   always #2 clk = ~clk;

   sp_len_framer dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_value(cmd_value), .cmd_rate_sel(cmd_rate_sel),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   int total = 0;
   int bad = 0;
   logic [7:0] got [0:511];
   int got_n = 0;

   typedef struct packed {
      logic [1:0]  op;
      logic [63:0] val;
      logic [3:0]  len;
      logic [79:0] exp;
   } vec_t;

   // Expected bytes are top-aligned: first byte in [79:72]. Ops 0 (R2) and 1 (R3); several cover R4.
   localparam vec_t VECS [10] = '{
      '{2'd0, 64'h0,                  4'd2, {8'h01, 8'h00, 64'h0}},
      '{2'd0, 64'h1,                  4'd2, {8'h01, 8'h01, 64'h0}},
      '{2'd0, 64'hFF,                 4'd2, {8'h01, 8'hFF, 64'h0}},
      '{2'd0, 64'h100,                4'd3, {8'h02, 8'h01, 8'h00, 56'h0}},
      '{2'd0, 64'h8000_0000_0000_0000, 4'd9, {8'h08, 8'h80, 56'h0, 8'h00}},
      '{2'd0, 64'h00AB_0000_0000_00CD, 4'd8, {8'h07, 8'hAB, 40'h0, 8'hCD, 16'h0}},
      '{2'd1, 64'h0,                  4'd2, {8'h00, 8'h01, 64'h0}},
      '{2'd1, 64'h100,                4'd3, {8'h01, 8'h00, 8'h02, 56'h0}},
      '{2'd1, 64'h0102_0304_0506_0708, 4'd9, {64'h0102_0304_0506_0708, 8'h08, 8'h00}},
      '{2'd1, 64'h0001_0000,          4'd4, {8'h01, 8'h00, 8'h00, 8'h03, 48'h0}}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [1:0] op, input logic [63:0] val, input bit sel,
                      input int npass, input bit stall);
      int idx = 0;
      int guard = 0;
      int stall_bad = 0;
      bit done = 0;
      logic pv = 1'b0;
      logic pr = 1'b1;
      logic [7:0] pd = '0;
      logic pl = 1'b0;
      got_n = 0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_value = val; cmd_rate_sel = sel;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0, "R10", "cmd_ready while busy", cmd_ready, 0);
      while (!done && guard < 5000) begin
         in_valid  = (idx < npass);
         in_data   = 8'(idx * 7 + 3);
         in_last   = (idx == npass - 1);
         out_ready = stall ? ((guard % 3) != 1) : 1'b1;
         #1;
         if (pv && !pr && !(out_valid && out_data == pd && out_last == pl)) stall_bad++;
         pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
         if (out_valid && out_ready) begin
            if (got_n < 512) got[got_n] = out_data;
            got_n++;
            if (out_last) done = 1;
         end
         if (in_valid && in_ready) idx++;
         guard++;
         @(negedge clk);
      end
      in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
      check(done, "R2", "operation finished (watchdog)", guard, 0);
      if (stall) check(stall_bad == 0, "R9", "output held during stall", stall_bad, 0);
   endtask

   task automatic verify(input string req, input int hlen, input logic [79:0] hdr,
                         input int npass, input int nzero);
      int mism = 0;
      int exp_total = hlen + npass + nzero;
      logic [7:0] e;
      logic [7:0] fa = '0;
      logic [7:0] fe = '0;
      for (int i = 0; i < got_n && i < 512; i++) begin
         if (i < hlen) e = hdr[79 - 8*i -: 8];
         else if (i < hlen + npass) e = 8'((i - hlen) * 7 + 3);
         else e = 8'h00;
         if (got[i] !== e) begin
            if (mism == 0) begin fa = got[i]; fe = e; end
            mism++;
         end
      end
      check(got_n == exp_total, req, "byte count", got_n, exp_total);
      check(mism == 0, req, "byte values (first mismatch)", fa, fe);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 0 && in_ready == 0 && cmd_ready == 1, "R1", "state in reset",
            {out_valid, in_ready, cmd_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 0 && cmd_ready == 1, "R1", "idle after reset",
            {out_valid, cmd_ready}, 2'b01);

      for (int v = 0; v < 10; v++) begin
         run(VECS[v].op, VECS[v].val, 1'b0, 0, 1'b0);
         verify(VECS[v].op == 2'd0 ? "R2" : "R3", int'(VECS[v].len), VECS[v].exp, 0, 0);
      end

      // R4 zero value and stripped interior, both orders with stall (R9)
      run(2'd0, 64'h0, 1'b0, 0, 1'b1);
      verify("R4", 2, {8'h01, 8'h00, 64'h0}, 0, 0);
      run(2'd1, 64'h0102_0304_0506_0708, 1'b0, 0, 1'b1);
      verify("R3", 9, {64'h0102_0304_0506_0708, 8'h08, 8'h00}, 0, 0);

      // R5 string headers
      run(2'd2, 64'd3, 1'b0, 3, 1'b0);
      verify("R5", 2, {8'h01, 8'h18, 64'h0}, 3, 0);
      run(2'd2, 64'd0, 1'b0, 0, 1'b0);
      verify("R5", 2, {8'h01, 8'h00, 64'h0}, 0, 0);
      run(2'd2, 64'd40, 1'b0, 40, 1'b1);
      verify("R5", 3, {8'h02, 8'h01, 8'h40, 56'h0}, 40, 0);

      // R6 headers, R7 fill, R8 aligned end
      run(2'd3, 64'd0, 1'b0, 10, 1'b0);
      verify("R6+R7", 2, {8'h01, 8'hA8, 64'h0}, 10, 156);
      run(2'd3, 64'd0, 1'b1, 134, 1'b0);
      verify("R6+R8", 2, {8'h01, 8'h88, 64'h0}, 134, 0);
      run(2'd3, 64'd0, 1'b1, 135, 1'b0);
      verify("R7", 2, {8'h01, 8'h88, 64'h0}, 135, 135);
      run(2'd3, 64'd0, 1'b0, 166, 1'b1);
      verify("R8", 2, {8'h01, 8'hA8, 64'h0}, 166, 0);
      run(2'd3, 64'd0, 1'b0, 167, 1'b1);
      verify("R7", 2, {8'h01, 8'hA8, 64'h0}, 167, 167);

      // R1 reset in the middle of an operation
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_rate_sel = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(out_valid == 0 && in_ready == 0 && cmd_ready == 1, "R1", "reset mid-operation",
            {out_valid, in_ready, cmd_ready}, 3'b001);
      rst_n = 1'b1;
      out_ready = 1'b1;
      run(2'd0, 64'h100, 1'b0, 0, 1'b0);
      verify("R1", 3, {8'h02, 8'h01, 8'h00, 56'h0}, 0, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule